// File: doc/BRIEF.md
# GPIO Edge Detect and Interrupt Combiner

This block watches up to 128 general-purpose input pins, organised as banks of 32. Each pin's level passes through a two-flop synchroniser. The block then compares the synchronised level with its value one cycle earlier. For pins configured as inputs, a rising or falling transition sets that pin's sticky status bit, provided the matching edge-enable bit is set. Software clears status bits by naming a bank and a mask, and every mask bit that is 1 clears one status bit.

The status bits drive three interrupt lines. Pin 0 and pin 1 each have a dedicated line. Every other pin shares the third line. While the core is halted, any change on a wake-capable input pin produces a one-cycle wake pulse. The set of wake-capable pins is fixed. Bus decoding stays outside the block. The direction and enable vectors come in as plain inputs.

A small arming state machine blanks detection after reset until the synchroniser and the previous-level register hold real pin values. Its states are ARM_FILL0, ARM_FILL1, ARM_FILL2 and ARM_LIVE. It has three transitions, FILL0→FILL1, FILL1→FILL2 and FILL2→LIVE, one per clock. It then stays in ARM_LIVE until reset.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin's status bit is set when that pin's synchronised level goes from 0 to 1, its rise_en bit is 1, and its pin_dir bit is 0. A pin_dir bit of 1 means output, and output pins never set status.
- R2: A pin's status bit is set when that pin's synchronised level goes from 1 to 0, its fall_en bit is 1, and it is an input (pin_dir bit 0).
- R3: While clr_stb is high, each 1 in clr_mask clears status bit (32*clr_bank + i) at the next clock edge. Mask bits of 0 leave their status bits unchanged.
- R4: If a clear and a newly detected edge reach the same status bit on the same clock edge, the bit ends up set.
- R5: irq_pin0 equals status bit 0 and irq_pin1 equals status bit 1, both taken from bank 0.
- R6: irq_shared is the OR of status bits 127..2.
- R7: wake_pulse is high for exactly one cycle when halted is high and the synchronised level of an input pin in the wake set changes. The wake set is, by bank 0..3: 0x8003FE1B, 0x002001FC, 0xEC080000, 0x0012007F.
- R8: Pins with index at or above LINES never set status and never cause a wake pulse.
- R9: A pin change driven just before clock edge k shows up in edge_stat and wake_pulse after edge k+2. No status bit and no wake pulse appears during the three cycles of arming after reset, even when pins are high from reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 128 | Raw pin levels (asynchronous) |
| pin_dir | input | 128 | 1 = output, 0 = input |
| rise_en | input | 128 | Rising-edge enables |
| fall_en | input | 128 | Falling-edge enables |
| clr_stb | input | 1 | Clear strobe |
| clr_bank | input | 2 | Bank addressed by the clear |
| clr_mask | input | 32 | Write-one-to-clear mask |
| halted | input | 1 | Core halted flag |
| edge_stat | output | 128 | Sticky edge status |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for all other pins |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
A pin change driven at a falling edge reaches the status register and the wake pulse on the third rising edge that follows. The bench therefore waits exactly three rising edges before it samples on the next falling edge. A clear is applied during the cycle that ends on that third edge, so each check observes the effects of both the edge and the clear. That timing also lets the same-cycle collision case be built directly. The interrupt lines follow the status combinationally and are sampled at the same point. The bench confirms that the wake pulse has dropped one cycle later, at the start of the next step.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        ARM_FILL0,
        ARM_FILL1,
        ARM_FILL2,
        ARM_LIVE
    } arm_state_t;

    // Fixed set of pins able to wake a halted core, per bank.
    function automatic logic [LANE_W-1:0] wake_lanes(input int bank);
        case (bank)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            3:       return 32'h0012_007F;
            default: return '0;
        endcase
    endfunction

    // Lanes of a bank whose pin index is below the configured line count.
    function automatic logic [LANE_W-1:0] live_lanes(input int bank, input int lines);
        logic [LANE_W-1:0] m;
        for (int i = 0; i < LANE_W; i++) begin
            m[i] = ((bank * LANE_W) + i) < lines;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    assign cur = cur_q;
    assign prv = prv_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter logic [31:0] VALID = '1,
    parameter logic [31:0] WAKE  = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        live,
    input  logic [31:0] cur,
    input  logic [31:0] prv,
    input  logic [31:0] dir,
    input  logic [31:0] rise,
    input  logic [31:0] fall,
    input  logic        clr_hit,
    input  logic [31:0] clr_mask,
    input  logic        halted,
    output logic [31:0] stat,
    output logic        wake_hit
);
    logic [31:0] stat_q;
    logic [31:0] set_v;
    logic [31:0] clr_v;
    logic [31:0] in_lanes;

    always_comb begin
        in_lanes = ~dir & VALID;
        set_v    = '0;
        if (live) begin
            set_v = in_lanes & ((rise & cur & ~prv) | (fall & ~cur & prv));
        end
        clr_v    = clr_hit ? clr_mask : '0;
        wake_hit = live && halted && (|((cur ^ prv) & in_lanes & WAKE));
    end

    // New edges are OR-ed in after the clear, so they win a collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_v) | set_v;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int W = 128
) (
    input  logic [W-1:0] stat,
    output logic         irq_a,
    output logic         irq_b,
    output logic         irq_rest
);
    assign irq_a    = stat[0];
    assign irq_b    = stat[1];
    assign irq_rest = |stat[W-1:2];
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int LINES     = 120,
    localparam int PIN_W    = NUM_BANKS * LANE_W,
    localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_lvl,
    input  logic [PIN_W-1:0]  pin_dir,
    input  logic [PIN_W-1:0]  rise_en,
    input  logic [PIN_W-1:0]  fall_en,
    input  logic              clr_stb,
    input  logic [BSEL_W-1:0] clr_bank,
    input  logic [31:0]       clr_mask,
    input  logic              halted,
    output logic [PIN_W-1:0]  edge_stat,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_shared,
    output logic              wake_pulse
);
    arm_state_t          st_q;
    arm_state_t          st_d;
    logic                live;
    logic [PIN_W-1:0]    cur;
    logic [PIN_W-1:0]    prv;
    logic [NUM_BANKS-1:0] wake_v;
    logic                wake_q;

    // Arming state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ARM_FILL0;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d = st_q;
        live = 1'b0;
        unique case (st_q)
            ARM_FILL0: st_d = ARM_FILL1;
            ARM_FILL1: st_d = ARM_FILL2;
            ARM_FILL2: st_d = ARM_LIVE;
            ARM_LIVE:  live = 1'b1;
        endcase
    end

    gpio_edge_sync #(.W(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_lvl),
        .cur   (cur),
        .prv   (prv)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [31:0] VMASK = live_lanes(b, LINES);
        localparam logic [31:0] WMASK = wake_lanes(b);
        gpio_edge_bank #(.VALID(VMASK), .WAKE(WMASK)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .live     (live),
            .cur      (cur[b*LANE_W +: LANE_W]),
            .prv      (prv[b*LANE_W +: LANE_W]),
            .dir      (pin_dir[b*LANE_W +: LANE_W]),
            .rise     (rise_en[b*LANE_W +: LANE_W]),
            .fall     (fall_en[b*LANE_W +: LANE_W]),
            .clr_hit  (clr_stb && (clr_bank == BSEL_W'(b))),
            .clr_mask (clr_mask),
            .halted   (halted),
            .stat     (edge_stat[b*LANE_W +: LANE_W]),
            .wake_hit (wake_v[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= |wake_v;
        end
    end

    assign wake_pulse = wake_q;

    gpio_irq_combine #(.W(PIN_W)) u_irq (
        .stat     (edge_stat),
        .irq_a    (irq_pin0),
        .irq_b    (irq_pin1),
        .irq_rest (irq_shared)
    );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int NUM_BANKS = 4,
    parameter int LINES     = 120,
    localparam int PIN_W    = NUM_BANKS * 32,
    localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PIN_W-1:0]  pin_dir,
    input logic              clr_stb,
    input logic [BSEL_W-1:0] clr_bank,
    input logic [31:0]       clr_mask,
    input logic              halted,
    input logic [PIN_W-1:0]  edge_stat,
    input logic              irq_pin0,
    input logic              irq_pin1,
    input logic              irq_shared,
    input logic              wake_pulse
);
    logic [PIN_W-1:0] valid_v;
    logic [PIN_W-1:0] clr_vec;
    logic [2:0]       age_q;

    always_comb begin
        for (int i = 0; i < PIN_W; i++) begin
            valid_v[i] = i < LINES;
        end
        clr_vec = clr_stb ? (PIN_W'(clr_mask) << (32 * int'(clr_bank))) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end

    AST_OUTPUT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_stat & ~$past(edge_stat) & $past(pin_dir)) == '0)); // R1
    AST_CLEAR_ONLY_BY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~edge_stat & $past(edge_stat) & ~$past(clr_vec)) == '0)); // R3
    AST_QUIET_WHEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stat == '0) |-> (!irq_pin0 && !irq_pin1 && !irq_shared)); // R6
    AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(halted)); // R7
    AST_UNUSED_PINS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_stat & ~valid_v) == '0)); // R8
    AST_ARMING_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < 3'd3) |-> ((edge_stat == '0) && !wake_pulse)); // R9
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_BANKS(NUM_BANKS), .LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_dir    (pin_dir),
    .clr_stb    (clr_stb),
    .clr_bank   (clr_bank),
    .clr_mask   (clr_mask),
    .halted     (halted),
    .edge_stat  (edge_stat),
    .irq_pin0   (irq_pin0),
    .irq_pin1   (irq_pin1),
    .irq_shared (irq_shared),
    .wake_pulse (wake_pulse)
);

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] pin_lvl, pin_dir, rise_en, fall_en;
    logic         clr_stb;
    logic [1:0]   clr_bank;
    logic [31:0]  clr_mask;
    logic         halted;
    logic [127:0] edge_stat;
    logic         irq_pin0, irq_pin1, irq_shared, wake_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [127:0] pins_m;
    logic [127:0] stat_m;

    localparam logic [127:0] WAKE_SET =
        {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};

    always #2 clk = ~clk;

    gpio_edge_irq #(.NUM_BANKS(4), .LINES(120)) i_gpio_edge_irq (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_dir(pin_dir),
        .rise_en(rise_en), .fall_en(fall_en), .clr_stb(clr_stb),
        .clr_bank(clr_bank), .clr_mask(clr_mask), .halted(halted),
        .edge_stat(edge_stat), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
        .irq_shared(irq_shared), .wake_pulse(wake_pulse)
    );

    function automatic logic [127:0] valid_pins();
        logic [127:0] v;
        for (int i = 0; i < 128; i++) v[i] = i < 120;
        return v;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One step: new pin levels, optional clear landing on the detection edge.
    task automatic step(input logic [127:0] np, input logic hv, input logic cs,
                        input logic [1:0] cb, input logic [31:0] cm, input string tag);
        logic [127:0] edges, clrv, expst;
        logic expw;
        edges = ((rise_en & np & ~pins_m) | (fall_en & ~np & pins_m)) & ~pin_dir & valid_pins();
        clrv  = cs ? ({96'b0, cm} << (32 * int'(cb))) : '0;
        expst = (stat_m & ~clrv) | edges;
        expw  = hv & (|((np ^ pins_m) & ~pin_dir & WAKE_SET & valid_pins()));
        @(negedge clk);
        check("R7 pulse ends", {127'b0, wake_pulse}, 128'b0);
        pin_lvl = np;
        halted  = hv;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        clr_stb = cs; clr_bank = cb; clr_mask = cm;
        @(posedge clk);
        @(negedge clk);
        clr_stb = 1'b0;
        check({tag, " status"}, edge_stat, expst);
        check("R7 wake", {127'b0, wake_pulse}, {127'b0, expw});
        check("R5 irq0", {127'b0, irq_pin0}, {127'b0, expst[0]});
        check("R5 irq1", {127'b0, irq_pin1}, {127'b0, expst[1]});
        check("R6 shared", {127'b0, irq_shared}, {127'b0, |expst[127:2]});
        pins_m = np;
        stat_m = expst;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [127:0] p;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; pin_dir = '0; rise_en = '1; fall_en = '0;
        clr_stb = 0; clr_bank = 0; clr_mask = 0; halted = 0;
        pin_lvl = 128'h1 | (128'h1 << 70);
        #1;
        check("R9 reset status", edge_stat, '0);
        check("R9 reset outputs", {124'b0, irq_pin0, irq_pin1, irq_shared, wake_pulse}, '0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (6) @(negedge clk);
        check("R9 arming no false edge", edge_stat, '0);
        pins_m = pin_lvl; stat_m = '0;
        pin_lvl = 0; pins_m = 0;
        repeat (4) @(negedge clk);
        stat_m = edge_stat;
        check("R9 settle", edge_stat, '0);

        p = 0;
        p[0] = 1; step(p, 1, 0, 0, 0, "R1 pin0 rise");
        step(p, 0, 1, 0, 32'h1, "R3 clear bit0");
        p[1] = 1; step(p, 0, 0, 0, 0, "R1 pin1 rise");
        step(p, 0, 1, 0, 32'h0, "R3 zero mask");
        p[40] = 1; step(p, 1, 0, 0, 0, "R6 pin40");
        p[125] = 1; step(p, 1, 0, 0, 0, "R8 beyond lines");
        pin_dir[3] = 1; p[3] = 1; step(p, 1, 0, 0, 0, "R1 output ignored");
        p[5] = 1; step(p, 0, 1, 0, 32'h20, "R4 collision");
        p[2] = 1; step(p, 1, 0, 0, 0, "R7 non-wake pin");
        fall_en = '1; rise_en = '0; p[40] = 0; step(p, 1, 0, 0, 0, "R2 pin40 fall");
        step(p, 0, 1, 1, 32'hFFFF_FFFF, "R3 clear bank1");

        for (int k = 0; k < 300; k++) begin
            logic [127:0] flips;
            @(negedge clk);
            pin_dir = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            rise_en = {$urandom, $urandom, $urandom, $urandom};
            fall_en = {$urandom, $urandom, $urandom, $urandom};
            flips = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
                    & {$urandom, $urandom, $urandom, $urandom};
            step(pins_m ^ flips, 1'($urandom), 1'(($urandom % 3) == 0), 2'($urandom),
                 $urandom, "R1 R2 R3 R4 R8 random");
        end
        summary();
    end
endmodule